// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block drives eight general-purpose pins. A direction register picks input or output for each pin, and a data register holds the output values. Both registers sit behind a small register bus with an address, a write enable, write data and combinational read data. Each pin has an output value, an output enable and an input. The pin inputs pass through a two-flop synchroniser before they reach the readback path.

Two bit positions behave differently from the rest. When the clock-output bit (default bit 6) is set as an output, it drives the system clock onto the pin, and on a read it always returns the synchronised pin level. The open-drain bits (default mask 8'h01, bit 0) never drive high. To produce a high they release the output enable, so they can sit on a shared wired-AND line. All other bits, including bit 7, drive both high and low when they are outputs.

A read of a data register bit returns the latched value if that bit is an output and the synchronised pin if it is an input.

Top module: `gpio_port`

## Requirements
- R1: After an active-low reset every direction bit and every stored data bit is 0, and all pin output enables are 0.
- R2: A 1 in direction bit n makes pin n an output. A push-pull bit then has pin_oe_o[n]=1 and pin_o[n] equal to the latched data bit.
- R3: A read at address 0 (the direction register) returns 8'h00.
- R4: A read at address 1 (the data register) returns the latched data for every output bit other than bit 6, whatever level is on the pin.
- R5: For an input bit, a data read returns pin_i after two clock edges of synchronisation. After one edge it still returns the older level.
- R6: When direction bit 6 is 1, pin_oe_o[6]=1 and pin_o[6] follows sys_clk_i. When direction bit 6 is 0, pin_oe_o[6]=0.
- R7: Data bit 6 is read-only. Writes to it are ignored, and reads always return the synchronised pin level, including just after reset.
- R8: An open-drain bit (mask 8'h01) always has pin_o=0. As an output it sets pin_oe_o to the inverse of its data bit, and as an input it sets pin_oe_o to 0.
- R9: A write with we_i=1 (address 0 for direction, 1 for data) takes effect at that clock edge and shows on the pins in the next cycle. With we_i=0 nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 1 | Register select: 0 direction, 1 data |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sys_clk_i | input | 1 | System clock to drive onto the clock-output pin |
| pin_i | input | 8 | Pin input levels (asynchronous) |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
The checker watches five rules on every cycle: direction reads return zero, the open-drain bit never drives high, a push-pull output reads back its driven value, output enables change only after a write, and the clock pin follows sys_clk_i whenever it is enabled. The following can only be shown by the bench's directed scenarios:
- the two-edge synchroniser latency;
- the bit-6 read-only behaviour across direction changes;
- the open-drain release sequence;
- the exact value of each readback mix.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 1;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  localparam reg_addr_t ADDR_DIR = 1'b0;
  localparam reg_addr_t ADDR_DAT = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CLK_BIT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_addr_t        addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] dat_o
);
  logic wr_dir, wr_dat;
  assign wr_dir = we_i && (addr_i == ADDR_DIR);
  assign wr_dat = we_i && (addr_i == ADDR_DAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_o <= '0;
    else if (wr_dir) dir_o <= wdata_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_dat
    if (b == CLK_BIT) begin : g_ro
      // read-only position: nothing stored
      assign dat_o[b] = 1'b0;
    end else begin : g_rw
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= 1'b0;
        else if (wr_dat) q <= wdata_i[b];
      end
      assign dat_o[b] = q;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned     WIDTH   = 8,
  parameter int unsigned     CLK_BIT = 6,
  parameter logic [WIDTH-1:0] OD_MASK = 8'h01
) (
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic             sys_clk_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pad
    if (b == CLK_BIT) begin : g_clk
      assign pin_oe_o[b] = dir_i[b];
      assign pin_o[b]    = dir_i[b] & sys_clk_i;
    end else if (OD_MASK[b]) begin : g_od
      // high = released
      assign pin_oe_o[b] = dir_i[b] & ~dat_i[b];
      assign pin_o[b]    = 1'b0;
    end else begin : g_pp
      assign pin_oe_o[b] = dir_i[b];
      assign pin_o[b]    = dat_i[b];
    end
  end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CLK_BIT = 6
) (
  input  reg_addr_t        addr_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic [WIDTH-1:0] pin_s_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] port_val;

  for (genvar b = 0; b < WIDTH; b++) begin : g_rb
    if (b == CLK_BIT) begin : g_live
      assign port_val[b] = pin_s_i[b];
    end else begin : g_mix
      assign port_val[b] = dir_i[b] ? dat_i[b] : pin_s_i[b];
    end
  end

  // direction register is write-only
  assign rdata_o = (addr_i == ADDR_DAT) ? port_val : '0;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH   = 8,
  parameter int unsigned      CLK_BIT = 6,
  parameter logic [WIDTH-1:0] OD_MASK = 8'h01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             sys_clk_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  logic [WIDTH-1:0] dir, dat, pin_s;

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  gpio_regs #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .dir_o(dir), .dat_o(dat)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT), .OD_MASK(OD_MASK)) u_pad (
    .dir_i(dir), .dat_i(dat), .sys_clk_i(sys_clk_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  gpio_readback #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT)) u_rb (
    .addr_i(addr_i), .dir_i(dir), .dat_i(dat), .pin_s_i(pin_s),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned      WIDTH   = 8,
  parameter int unsigned      CLK_BIT = 6,
  parameter logic [WIDTH-1:0] OD_MASK = 8'h01,
  parameter int unsigned      PP_BIT  = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             addr_i,
  input logic             we_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             sys_clk_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o
);
  a_r1_reset_released: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_oe_o == '0));

  a_r3_dir_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 1'b0) |-> (rdata_o == '0));

  a_r4_output_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 1'b1 && pin_oe_o[PP_BIT]) |-> (rdata_o[PP_BIT] == pin_o[PP_BIT]));

  a_r6_clk_pin_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o[CLK_BIT] |-> (pin_o[CLK_BIT] == sys_clk_i));

  a_r8_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o & OD_MASK) == '0));

  a_r9_oe_holds_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pin_oe_o));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .CLK_BIT(CLK_BIT), .OD_MASK(OD_MASK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .rdata_o(rdata_o), .sys_clk_i(sys_clk_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_i = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       sys_clk_i = 1'b0;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_o, pin_oe_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_port u0 (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic a, logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic reg_rd(logic a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    pin_i = 8'hE5;
    #1;
    check("R1 oe in reset", pin_oe_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    settle(3);
    reg_rd(1'b1, r);
    check("R1 inputs read pins", r, 8'hE5);
    check("R7 bit6 after reset", {7'b0, r[6]}, 8'h01);
  endtask

  task automatic t_dir_read();
    logic [7:0] r;
    reg_wr(1'b0, 8'hFF);
    reg_rd(1'b0, r);
    check("R3 dir read zero", r, 8'h00);
  endtask

  task automatic t_outputs();
    logic [7:0] r;
    pin_i = 8'h55; sys_clk_i = 1'b1;
    reg_wr(1'b1, 8'hAA);
    settle(2);
    check("R2 oe all out", pin_oe_o, 8'hFF);
    check("R2 pin values", pin_o, 8'hEA);
    reg_rd(1'b1, r);
    check("R4 output readback", r, 8'hEA);
    sys_clk_i = 1'b0; #1;
    check("R6 clk pin low", {7'b0, pin_o[6]}, 8'h00);
    sys_clk_i = 1'b1; #1;
    check("R6 clk pin high", {7'b0, pin_o[6]}, 8'h01);
  endtask

  task automatic t_open_drain();
    reg_wr(1'b1, 8'h01);
    check("R8 od released", {7'b0, pin_oe_o[0]}, 8'h00);
    check("R8 od pin low", {7'b0, pin_o[0]}, 8'h00);
    reg_wr(1'b1, 8'h00);
    check("R8 od driven", {7'b0, pin_oe_o[0]}, 8'h01);
  endtask

  task automatic t_no_write();
    addr_i = 1'b0; wdata_i = 8'h00; we_i = 1'b0;
    settle(2);
    check("R9 no write holds", pin_oe_o, 8'hFF);
    addr_i = 1'b0; wdata_i = 8'h00; we_i = 1'b1; #1;
    check("R9 before edge", pin_oe_o, 8'hFF);
    @(posedge clk_i); @(negedge clk_i); we_i = 1'b0;
    check("R9 after edge", pin_oe_o, 8'h00);
    check("R6 clk pin off", {7'b0, pin_o[6]}, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] r;
    pin_i = 8'h3C;
    @(posedge clk_i); @(negedge clk_i);
    reg_rd(1'b1, r);
    check("R5 one edge old", r, 8'h55);
    @(posedge clk_i); @(negedge clk_i);
    reg_rd(1'b1, r);
    check("R5 two edges new", r, 8'h3C);
  endtask

  task automatic t_bit6_ro();
    logic [7:0] r;
    reg_wr(1'b1, 8'h40);
    pin_i = 8'h00;
    reg_wr(1'b0, 8'h40);
    settle(2);
    reg_rd(1'b1, r);
    check("R7 bit6 reads pin", r, 8'h00);
    pin_i = 8'h40; settle(2);
    reg_rd(1'b1, r);
    check("R7 bit6 live pin", r, 8'h40);
    check("R6 clk pin enabled", pin_oe_o, 8'h40);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_dir_read();
    t_outputs();
    t_open_drain();
    t_no_write();
    t_sync();
    t_bit6_ro();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule